// File: doc/BRIEF.md
# Indirect-Addressed Processor Register Port for a TDM Switch

This block is the host-side access port of a time-slot switch. A processor drives an 8-bit data bus, six address lines, an active-low chip select, an active-high data strobe and a read/write line. It gets back read data and an active-low acknowledge. One 8-bit setup register is reached directly. The three 256-entry switch memories are reached indirectly: the setup register names the memory and the stream (the upper address bits), and the address pins give the channel within that stream. The memories are connection low, connection high, and the received-data memory, which the processor can only read.

The switch memories are shared with the periodic TDM datapath. For that reason the port does not touch them directly. It raises a request on a small memory interface and waits for a grant, which an external scheduler gives in a free slot. The acknowledge therefore comes after a variable number of cycles. Once the transfer is complete, the acknowledge stays low until the processor releases the strobe. A split mode in the setup register sends every read to the received-data memory and every write to connection low. The message-enable bit of the setup register is also brought out for the switching datapath.

Top module: `cpuRegPort`

## Requirements
- R1: An active access (csN low and ds high) with addr[5]=0 and addr[1:0]=00 targets the setup register. A write stores all 8 bits of wrData, and a read returns the stored value on rdData. This holds whether split mode is on or off.
- R2: An access with addr[5]=1 addresses memory location {setup[2:0], addr[4:0]} on memAddr. The stream number is the upper 3 bits and the channel is the lower 5 bits.
- R3: With setup[7]=0, setup[4:3] selects the memory and is presented on memSel: 01 is received data, 10 is connection low, 11 is connection high. memWe is 1 for writes, and memWdata carries wrData.
- R4: With setup[7]=1 (split mode), memory reads use memSel=01 and memory writes use memSel=10, whatever setup[4:3] holds.
- R5: A memory write whose effective select is 01 or 00 raises no request and changes no memory, but it is still acknowledged. A memory read with select 00, or any access with addr[5]=0 and addr[1:0] not 00, raises no request, and such a read returns 0.
- R6: memReq stays high until a cycle with memGnt high. On a read, memRdata in that grant cycle becomes rdData. The acknowledge falls 2+G cycles after the strobe is first sampled, where G is the number of request cycles without a grant.
- R7: Accesses that need no memory slot are acknowledged one cycle after the strobe is sampled. ackN stays low for as long as the strobe is held and returns high one cycle after the strobe is released.
- R8: msgEnable always equals setup bit 6.
- R9: After reset the setup register is 0, ackN is 1 and memReq is 0.
- R10: While csN is high or ds is low, the port raises no request, keeps ackN high and leaves the setup register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| ds | input | 1 | Data strobe, active high |
| rdWr | input | 1 | 1 = read, 0 = write |
| addr | input | 6 | Processor address |
| wrData | input | 8 | Processor write data |
| rdData | output | 8 | Processor read data, valid while ackN is low |
| ackN | output | 1 | Transfer-complete acknowledge, active low |
| msgEnable | output | 1 | Setup bit 6, for the switching datapath |
| memReq | output | 1 | Request for a memory slot |
| memSel | output | 2 | Target memory code (01 data, 10 low, 11 high) |
| memWe | output | 1 | Request is a write |
| memAddr | output | 8 | {stream, channel} location |
| memWdata | output | 8 | Data for a memory write |
| memGnt | input | 1 | Slot granted this cycle |
| memRdata | input | 8 | Read data, valid in the grant cycle |

## Verification
The assertions assume two things about the inputs. First, the processor holds address, read/write and write data steady from the moment the strobe is raised until it sees the acknowledge. Second, the scheduler raises memGnt only while memReq is high. The bench respects both. Each access is driven on a falling edge and left unchanged until the acknowledge appears and the strobe is dropped. The bench's scheduler model grants only in a cycle where it sees a live request, after a programmable number of waiting cycles.

// File: rtl/cpuPortPkg.sv
package cpuPortPkg;
  localparam int DataW   = 8;
  localparam int AddrW   = 6;
  localparam int ChanW   = 5;
  localparam int StreamW = 3;
  localparam int MemAW   = StreamW + ChanW;

  localparam logic [1:0] SelNone = 2'b00;
  localparam logic [1:0] SelData = 2'b01;
  localparam logic [1:0] SelLow  = 2'b10;
  localparam logic [1:0] SelHigh = 2'b11;

  typedef enum logic [1:0] {PortIdle, PortWait, PortDone} portState_t;

  typedef struct packed {
    logic setupWr;
    logic setupRd;
    logic zeroRd;
    logic memLatch;
  } portStrobe_t;
endpackage

// File: rtl/cpuPortData.sv
module cpuPortData
  import cpuPortPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  portStrobe_t        stb,
  input  logic               rdWr,
  input  logic [AddrW-1:0]   addr,
  input  logic [DataW-1:0]   wrData,
  input  logic [DataW-1:0]   memRdata,
  output logic               decSetup,
  output logic               decMem,
  output logic [1:0]         memSel,
  output logic [MemAW-1:0]   memAddr,
  output logic [DataW-1:0]   memWdata,
  output logic [DataW-1:0]   rdData,
  output logic               msgEnable
);
  logic [DataW-1:0] setupReg;
  logic             splitOn;
  logic [1:0]       selField;

  assign splitOn   = setupReg[7];
  assign selField  = setupReg[4:3];
  assign msgEnable = setupReg[6];

  // Address decode: direct setup register vs. indirect memory window
  assign decSetup = !addr[5] && (addr[1:0] == 2'b00);

  always_comb begin
    if (splitOn) memSel = rdWr ? SelData : SelLow;
    else         memSel = selField;
  end

  always_comb begin
    if (!addr[5])  decMem = 1'b0;
    else if (rdWr) decMem = (memSel != SelNone);
    else           decMem = (memSel == SelLow) || (memSel == SelHigh);
  end

  assign memAddr  = {setupReg[StreamW-1:0], addr[ChanW-1:0]};
  assign memWdata = wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) setupReg <= '0;
    else if (stb.setupWr) setupReg <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdData <= '0;
    else if (stb.setupRd)  rdData <= setupReg;
    else if (stb.zeroRd)   rdData <= '0;
    else if (stb.memLatch) rdData <= memRdata;
  end

  // R10: setup register only moves on a decoded write strobe
  assert_setup_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.setupWr) |-> $stable(setupReg));
  // R8: message enable output tracks setup bit 6 after a write
  assert_msg_follow_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.setupWr |=> (msgEnable == $past(wrData[6])));
endmodule

// File: rtl/cpuPortCtrl.sv
module cpuPortCtrl
  import cpuPortPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        ds,
  input  logic        rdWr,
  input  logic        decSetup,
  input  logic        decMem,
  input  logic        memGnt,
  output portStrobe_t stb,
  output logic        memReq,
  output logic        memWe,
  output logic        ackN
);
  portState_t state, stateNext;
  logic       strobeOn;

  assign strobeOn = !csN && ds;

  always_comb begin
    stateNext = state;
    stb       = '0;
    case (state)
      PortIdle: if (strobeOn) begin
        if (decSetup) begin
          stb.setupWr = !rdWr;
          stb.setupRd = rdWr;
          stateNext   = PortDone;
        end else if (decMem) begin
          stateNext = PortWait;
        end else begin
          stb.zeroRd = rdWr;
          stateNext  = PortDone;
        end
      end
      PortWait: if (memGnt) begin
        stb.memLatch = rdWr;
        stateNext    = PortDone;
      end
      PortDone: if (!strobeOn) stateNext = PortIdle;
      default:  stateNext = PortIdle;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PortIdle;
    else       state <= stateNext;
  end

  assign memReq = (state == PortWait);
  assign memWe  = memReq && !rdWr;
  assign ackN   = (state != PortDone);

  // R6: an ungranted request persists
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memGnt) |=> memReq);
  // R7: acknowledge releases one cycle after the strobe goes away
  assert_ack_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!ackN && !strobeOn) |=> ackN);
  // R7: acknowledge persists while the strobe is held
  assert_ack_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!ackN && strobeOn) |=> !ackN);
  // R10: no request without a live strobe having started it
  assert_no_idle_req_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) |-> $past(strobeOn));
  // R6: request and acknowledge never overlap
  assert_req_ack_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memReq, !ackN}));
endmodule

// File: rtl/cpuRegPort.sv
module cpuRegPort
  import cpuPortPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             ds,
  input  logic             rdWr,
  input  logic [5:0]       addr,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData,
  output logic             ackN,
  output logic             msgEnable,
  output logic             memReq,
  output logic [1:0]       memSel,
  output logic             memWe,
  output logic [7:0]       memAddr,
  output logic [7:0]       memWdata,
  input  logic             memGnt,
  input  logic [7:0]       memRdata
);
  portStrobe_t stb;
  logic        decSetup;
  logic        decMem;

  cpuPortCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .ds(ds), .rdWr(rdWr),
    .decSetup(decSetup), .decMem(decMem), .memGnt(memGnt),
    .stb(stb), .memReq(memReq), .memWe(memWe), .ackN(ackN)
  );

  cpuPortData u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .rdWr(rdWr), .addr(addr),
    .wrData(wrData), .memRdata(memRdata), .decSetup(decSetup),
    .decMem(decMem), .memSel(memSel), .memAddr(memAddr),
    .memWdata(memWdata), .rdData(rdData), .msgEnable(msgEnable)
  );

  // R5: no write request is ever aimed at the received-data memory
  assert_no_data_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |-> (memSel != SelData) && (memSel != SelNone));
endmodule

// File: tb/cpuRegPort_tb.sv
module cpuRegPort_tb;
  logic clk = 0, rstN = 0;
  logic csN = 1, ds = 0, rdWr = 1;
  logic [5:0] addr = 0;
  logic [7:0] wrData = 0;
  logic [7:0] rdData;
  logic ackN, msgEnable, memReq, memWe;
  logic [1:0] memSel;
  logic [7:0] memAddr, memWdata;
  logic memGnt = 0;
  logic [7:0] memRdata = 0;

  int checks = 0, fails = 0;
  int gntDelay = 0, waitCnt = 0, grantCount = 0;
  logic [7:0] dMem [256];
  logic [7:0] lMem [256];
  logic [7:0] hMem [256];

  always #4 clk = ~clk;

  cpuRegPort u_dut (.*);

  // Scheduler model: grants after gntDelay waiting cycles
  initial begin
    for (int i = 0; i < 256; i++) begin
      dMem[i] = 8'(i ^ 8'h5A); lMem[i] = 0; hMem[i] = 0;
    end
    forever begin
      @(negedge clk);
      memGnt = 0;
      if (memReq) begin
        if (waitCnt == gntDelay) begin
          waitCnt = 0; memGnt = 1; grantCount++;
          case (memSel)
            2'b01: memRdata = dMem[memAddr];
            2'b10: begin memRdata = lMem[memAddr]; if (memWe) lMem[memAddr] = memWdata; end
            2'b11: begin memRdata = hMem[memAddr]; if (memWe) hMem[memAddr] = memWdata; end
            default: memRdata = 8'hxx;
          endcase
        end else waitCnt++;
      end
    end
  end

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input logic rd, input logic [5:0] a, input logic [7:0] d,
                        input int hold, output logic [7:0] q, output int cyc);
    @(negedge clk);
    rdWr = rd; addr = a; wrData = d; csN = 0; ds = 1;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (ackN && cyc < 100);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R7 ack held", ackN, 0);
    end
    q = rdData;
    ds = 0; csN = 1;
    @(negedge clk);
    check("R7 ack release", ackN, 1);
  endtask

  task automatic testReset();
    logic [7:0] q; int c;
    check("R9 ackN", ackN, 1);
    check("R9 memReq", memReq, 0);
    check("R9 msgEnable", msgEnable, 0);
    access(1, 6'h00, 0, 0, q, c);
    check("R9 setup reset value", q, 0);
  endtask

  task automatic testSetup();
    logic [7:0] q; int c;
    access(0, 6'h04, 8'h6B, 0, q, c);   // addr[2]=1 with A5,A1,A0 low still hits setup
    check("R7 setup ack latency", c, 1);
    check("R8 msgEnable", msgEnable, 1);
    access(1, 6'h00, 0, 2, q, c);
    check("R1 setup readback", q, 8'h6B);
    access(0, 6'h00, 8'h2B, 0, q, c);
    check("R8 msgEnable cleared", msgEnable, 0);
  endtask

  task automatic testConnWrite();
    logic [7:0] q; int c;
    gntDelay = 1;
    access(0, 6'h00, 8'h13, 0, q, c);       // ms=10, stream 3
    access(0, 6'h27, 8'hC4, 0, q, c);       // channel 7
    check("R2 R3 low write landed", lMem[3*32+7], 8'hC4);
    check("R6 write latency G=1", c, 3);
    access(1, 6'h27, 0, 0, q, c);
    check("R3 low readback", q, 8'hC4);
    access(0, 6'h00, 8'h1D, 0, q, c);       // ms=11, stream 5
    access(0, 6'h3F, 8'h47, 0, q, c);
    check("R3 high write landed", hMem[5*32+31], 8'h47);
    check("R3 low untouched", lMem[5*32+31], 0);
  endtask

  task automatic testDataRead();
    logic [7:0] q; int c;
    gntDelay = 4;
    access(0, 6'h00, 8'h0E, 0, q, c);       // ms=01, stream 6
    access(1, 6'h22, 0, 0, q, c);
    check("R6 data read value", q, (6*32+2) ^ 8'h5A);
    check("R6 read latency G=4", c, 6);
  endtask

  task automatic testIgnored();
    logic [7:0] q; int c, g;
    gntDelay = 0;
    g = grantCount;
    access(0, 6'h22, 8'hEE, 0, q, c);       // write to data memory
    check("R5 data write acked fast", c, 1);
    check("R5 data write no request", grantCount, g);
    check("R5 data memory unchanged", dMem[6*32+2], (6*32+2) ^ 8'h5A);
    access(0, 6'h00, 8'h01, 0, q, c);       // ms=00, stream 1
    access(1, 6'h21, 0, 0, q, c);
    check("R5 sel00 read zero", q, 0);
    access(0, 6'h21, 8'h99, 0, q, c);
    check("R5 sel00 no request", grantCount, g);
    access(1, 6'h01, 0, 0, q, c);           // A5=0, A1A0!=0
    check("R5 unmapped read zero", q, 0);
    check("R5 unmapped latency", c, 1);
  endtask

  task automatic testSplit();
    logic [7:0] q; int c;
    gntDelay = 2;
    access(0, 6'h00, 8'h9A, 0, q, c);       // split, ms=11, stream 2
    access(0, 6'h29, 8'h3C, 0, q, c);
    check("R4 split write to low", lMem[2*32+9], 8'h3C);
    check("R4 split not to high", hMem[2*32+9], 0);
    access(1, 6'h29, 0, 0, q, c);
    check("R4 split read from data", q, (2*32+9) ^ 8'h5A);
    access(1, 6'h00, 0, 0, q, c);
    check("R1 setup read in split", q, 8'h9A);
    access(0, 6'h00, 8'h1A, 0, q, c);
    access(1, 6'h29, 0, 0, q, c);
    check("R4 split off reads high", q, 0);
  endtask

  task automatic testInactive();
    logic [7:0] q; int c, g;
    g = grantCount;
    @(negedge clk);
    rdWr = 0; addr = 6'h00; wrData = 8'hFF; csN = 1; ds = 1;
    repeat (3) @(negedge clk);
    check("R10 csN high no ack", ackN, 1);
    csN = 0; ds = 0; addr = 6'h29;
    repeat (3) @(negedge clk);
    check("R10 ds low no ack", ackN, 1);
    check("R10 no request", grantCount, g);
    csN = 1;
    access(1, 6'h00, 0, 0, q, c);
    check("R10 setup unchanged", q, 8'h1A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testSetup();
    testConnWrite();
    testDataRead();
    testIgnored();
    testSplit();
    testInactive();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule